// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

A single 16-bit interval timer that counts down once per prescaled tick of the bus clock. A 4-bit divider code in the control register picks the tick rate as the bus clock divided by a power of two, from 1 up to 32768. When a tick finds the count at zero, the timer raises a sticky event flag. It then either restores the count from a modulus register or wraps to all ones. The flag drives an interrupt request when its enable bit is set. Software clears the flag by writing a one to its bit.

Software reaches the timer through a simple register port that is read combinationally and written on the clock edge. The port has a privilege input, and a non-privileged access changes nothing, reads back zero and raises an error strobe. Two freeze inputs, a low-power doze request and a debug halt request, each stop the timer while their matching control bit is set. The timer then resumes from exactly the state it held.

The register map uses word addresses. Address 0 is control, address 1 is the modulus, address 2 is the live count (read only), and address 3 reads zero. In the control register, bits 11:8 hold the divider code, bit 6 is doze-freeze, bit 5 is debug-freeze, bit 4 is immediate-load, bit 3 is the event flag, bit 2 is the interrupt enable, bit 1 is reload and bit 0 is run.

Top module: `pit_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the modulus and the count both read 0xFFFF, and `irq` is low.
- R2: With run (bit 0) set and divider code p in bits 11:8, the count drops by one every 2^p clock edges. The first drop falls 2^p edges after the edge that captured the write enabling the timer from a cleared prescaler.
- R3: A control write whose divider code differs from the stored one clears the prescaler. The next drop then falls a full 2^p edges after that write's edge.
- R4: A modulus write with immediate-load (bit 4) set copies the written value into the count at that edge and clears the prescaler. With bit 4 clear, the write leaves the count untouched.
- R5: A tick that finds the count at zero sets the event flag (bit 3). With reload (bit 1) set, it also restores the count from the modulus, which gives a period of modulus+1 ticks.
- R6: With reload clear, a tick at zero sets the event flag and wraps the count to 0xFFFF.
- R7: Clearing run holds both the count and the prescaler. Setting run again with an unchanged divider code resumes from the held prescaler phase.
- R8: With doze-freeze (bit 6) set, a high `doze_in` freezes the count and the prescaler, and counting resumes from the same state when `doze_in` falls. With bit 6 clear, `doze_in` has no effect.
- R9: With debug-freeze (bit 5) set, a high `halt_in` freezes the count and the prescaler in the same way.
- R10: Writing 1 to bit 3 clears the event flag, and writing 0 there leaves it unchanged. A set from a tick at zero wins over a clear in the same cycle.
- R11: `irq` is high exactly when the event flag and the interrupt enable (bit 2) are both set.
- R12: Control bits 15:12 and bit 7 ignore writes and read as zero.
- R13: An access with `bus_priv` low writes nothing, returns zero read data and asserts `bus_err` during the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access, 0 = user access |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| bus_err | output | 1 | Error strobe for a non-privileged access |
| doze_in | input | 1 | Low-power doze request |
| halt_in | input | 1 | Debug halt request |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the edge that captures it, and its readback is valid half a cycle later. With divider code p, a count decrement lands 2^p edges after the enabling write's edge. A wrap, with its flag set and its reload or rollover, lands on the edge after the count reached zero. The bench drives every access at a falling edge and samples one time unit later, with no extra clock in between. It advances time only in whole cycles, falling edge to falling edge, so each expected count follows from the number of rising edges since the write. The holding and freezing cases are checked by reading the live count after several edges during which it must not move. The resume cases are checked by counting the edges to the next decrement.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int PRE_W   = 4;
   localparam int PRE_LSB = 8;

   localparam int B_DOZE = 6;
   localparam int B_DBG  = 5;
   localparam int B_OVW  = 4;
   localparam int B_PIF  = 3;
   localparam int B_PIE  = 2;
   localparam int B_RLD  = 1;
   localparam int B_EN   = 0;

   localparam int A_CTRL = 0;
   localparam int A_MOD  = 1;
   localparam int A_CNT  = 2;

   typedef struct packed {
      logic [PRE_W-1:0] pre;
      logic             doze;
      logic             dbg;
      logic             ovw;
      logic             pie;
      logic             rld;
      logic             en;
   } ctrl_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int PRE_W = 4,
   parameter int PSC_W = (1 << PRE_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             run,
   input  logic             clr,
   input  logic [PRE_W-1:0] pre,
   output logic             tick,
   output logic [PSC_W-1:0] cnt
);
   logic [PSC_W-1:0] limit;
   logic             active;

   if (PSC_W < 1) begin : g_bad_psc
      $error("pit_prescaler: PSC_W must be at least 1");
   end

   assign limit  = PSC_W'((32'd1 << pre) - 32'd1);
   assign active = en & run;
   assign tick   = active & (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (active) begin
         cnt <= tick ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             rld,
   input  logic [CNT_W-1:0] modulus,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic at_zero;

   assign at_zero = (count == '0);
   assign wrap    = tick & at_zero & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '1;
      end else if (load) begin
         count <= load_val;
      end else if (tick) begin
         if (at_zero) begin
            count <= rld ? modulus : '1;
         end else begin
            count <= count - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic              priv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err,
   input  logic [CNT_W-1:0]  count,
   input  logic              wrap,
   output ctrl_t             ctrl,
   output logic              pif,
   output logic [CNT_W-1:0]  modulus,
   output logic              load,
   output logic              pre_chg
);
   logic              acc_ok;
   logic              wr_ctrl;
   logic              wr_mod;
   logic              clr_flag;
   logic [DATA_W-1:0] ctrl_rd;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   assign acc_ok   = sel & priv;
   assign err      = sel & ~priv;
   assign wr_ctrl  = acc_ok & wr & (addr == ADDR_W'(A_CTRL));
   assign wr_mod   = acc_ok & wr & (addr == ADDR_W'(A_MOD));
   assign load     = wr_mod & ctrl.ovw;
   assign pre_chg  = wr_ctrl & (wdata[PRE_LSB +: PRE_W] != ctrl.pre);
   assign clr_flag = wr_ctrl & wdata[B_PIF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl.pre  <= wdata[PRE_LSB +: PRE_W];
         ctrl.doze <= wdata[B_DOZE];
         ctrl.dbg  <= wdata[B_DBG];
         ctrl.ovw  <= wdata[B_OVW];
         ctrl.pie  <= wdata[B_PIE];
         ctrl.rld  <= wdata[B_RLD];
         ctrl.en   <= wdata[B_EN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pif <= 1'b0;
      end else if (wrap) begin
         pif <= 1'b1;
      end else if (clr_flag) begin
         pif <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         modulus <= '1;
      end else if (wr_mod) begin
         modulus <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      ctrl_rd                      = '0;
      ctrl_rd[PRE_LSB +: PRE_W]    = ctrl.pre;
      ctrl_rd[B_DOZE]              = ctrl.doze;
      ctrl_rd[B_DBG]               = ctrl.dbg;
      ctrl_rd[B_OVW]               = ctrl.ovw;
      ctrl_rd[B_PIF]               = pif;
      ctrl_rd[B_PIE]               = ctrl.pie;
      ctrl_rd[B_RLD]               = ctrl.rld;
      ctrl_rd[B_EN]                = ctrl.en;
   end

   always_comb begin
      rdata = '0;
      if (acc_ok && !wr) begin
         if (addr == ADDR_W'(A_CTRL)) begin
            rdata = ctrl_rd;
         end else if (addr == ADDR_W'(A_MOD)) begin
            rdata = DATA_W'(modulus);
         end else if (addr == ADDR_W'(A_CNT)) begin
            rdata = DATA_W'(count);
         end
      end
   end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
   import pit_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 2,
   parameter int FREEZE_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_priv,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_err,
   input  logic              doze_in,
   input  logic              halt_in,
   output logic              irq
);
   localparam int PSC_W = (1 << PRE_W) - 1;

   if (DATA_W < PRE_LSB + PRE_W) begin : g_bad_data
      $error("pit_timer: DATA_W too narrow for the control layout");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pit_timer: CNT_W must lie in 2..DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pit_timer: ADDR_W must be at least 2");
   end

   ctrl_t            ctrl;
   logic             pif;
   logic [CNT_W-1:0] modulus;
   logic [CNT_W-1:0] count;
   logic [PSC_W-1:0] presc;
   logic             load;
   logic             pre_chg;
   logic             tick;
   logic             wrap;
   logic             run;
   logic             doze_q;
   logic             halt_q;

   if (FREEZE_SYNC != 0) begin : g_sync
      logic [1:0] dz_pipe;
      logic [1:0] hl_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dz_pipe <= '0;
            hl_pipe <= '0;
         end else begin
            dz_pipe <= {dz_pipe[0], doze_in};
            hl_pipe <= {hl_pipe[0], halt_in};
         end
      end
      assign doze_q = dz_pipe[1];
      assign halt_q = hl_pipe[1];
   end else begin : g_direct
      assign doze_q = doze_in;
      assign halt_q = halt_in;
   end

   assign run = ~(ctrl.doze & doze_q) & ~(ctrl.dbg & halt_q);
   assign irq = pif & ctrl.pie;

   pit_regs #(
      .CNT_W (CNT_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (bus_sel),
      .wr     (bus_wr),
      .priv   (bus_priv),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .rdata  (bus_rdata),
      .err    (bus_err),
      .count  (count),
      .wrap   (wrap),
      .ctrl   (ctrl),
      .pif    (pif),
      .modulus(modulus),
      .load   (load),
      .pre_chg(pre_chg)
   );

   pit_prescaler #(
      .PRE_W(PRE_W),
      .PSC_W(PSC_W)
   ) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ctrl.en),
      .run  (run),
      .clr  (pre_chg | load),
      .pre  (ctrl.pre),
      .tick (tick),
      .cnt  (presc)
   );

   pit_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load    (load),
      .load_val(bus_wdata[CNT_W-1:0]),
      .rld     (ctrl.rld),
      .modulus (modulus),
      .count   (count),
      .wrap    (wrap)
   );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int PSC_W  = (1 << PRE_W) - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              wr,
   input logic              priv,
   input logic              err,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] wdata,
   input logic [PRE_W+5:0]  ctrl_bits,
   input logic              en,
   input logic              rld,
   input logic              pif,
   input logic [PRE_W-1:0]  pre,
   input logic              run,
   input logic              tick,
   input logic              load,
   input logic              pre_chg,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  modulus,
   input logic [PSC_W-1:0]  presc
);
   logic [PSC_W-1:0] limit;
   assign limit = PSC_W'((32'd1 << pre) - 32'd1);

   assert_presc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      presc <= limit);

   assert_pre_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pre_chg |=> (presc == '0));

   assert_load_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(wdata[CNT_W-1:0])) && (presc == '0));

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0 && rld && !load) |=> (count == $past(modulus)) && pif);

   assert_rollover_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0 && !rld && !load) |=> (count == '1) && pif);

   assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(count));

   assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !sel) |=> $stable(count) && $stable(presc));

   assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pif) |-> $past(tick && count == '0));

   assert_user_nowrite_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && !priv) |=> $stable(ctrl_bits) && $stable(modulus));

   assert_user_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !priv) |-> err && (rdata == '0));
endmodule

bind pit_timer pit_timer_chk #(
   .CNT_W (CNT_W),
   .DATA_W(DATA_W),
   .PSC_W (PSC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel      (bus_sel),
   .wr       (bus_wr),
   .priv     (bus_priv),
   .err      (bus_err),
   .rdata    (bus_rdata),
   .wdata    (bus_wdata),
   .ctrl_bits(ctrl),
   .en       (ctrl.en),
   .rld      (ctrl.rld),
   .pif      (pif),
   .pre      (ctrl.pre),
   .run      (run),
   .tick     (tick),
   .load     (load),
   .pre_chg  (pre_chg),
   .count    (count),
   .modulus  (modulus),
   .presc    (presc)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
   localparam int CLK_PERIOD = 10;

   localparam int A_CTRL = 0;
   localparam int A_MOD  = 1;
   localparam int A_CNT  = 2;

   localparam int F_EN   = 'h0001;
   localparam int F_RLD  = 'h0002;
   localparam int F_PIE  = 'h0004;
   localparam int F_PIF  = 'h0008;
   localparam int F_OVW  = 'h0010;
   localparam int F_DBG  = 'h0020;
   localparam int F_DOZE = 'h0040;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_priv = 1'b1;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err;
   logic        doze_in = 1'b0;
   logic        halt_in = 1'b0;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic last_err;

   pit_timer u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_priv (bus_priv),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .bus_err  (bus_err),
      .doze_in  (doze_in),
      .halt_in  (halt_in),
      .irq      (irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // caller sits at a falling edge; one rising edge passes inside
   task automatic wr_reg(input int a, input int d, input bit priv = 1'b1);
      bus_sel   = 1'b1;
      bus_wr    = 1'b1;
      bus_priv  = priv;
      bus_addr  = a[1:0];
      bus_wdata = d[15:0];
      #1;
      last_err = bus_err;
      @(negedge clk);
      bus_sel  = 1'b0;
      bus_wr   = 1'b0;
      bus_priv = 1'b1;
   endtask

   // combinational read, no clock edge passes
   task automatic rd_reg(input int a, output int v, input bit priv = 1'b1);
      bus_sel  = 1'b1;
      bus_wr   = 1'b0;
      bus_priv = priv;
      bus_addr = a[1:0];
      #1;
      v        = int'(bus_rdata);
      last_err = bus_err;
      bus_sel  = 1'b0;
      bus_priv = 1'b1;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_reg(input string req, input string what, input int a, input int exp);
      int v;
      rd_reg(a, v);
      chk(req, what, v, exp);
   endtask

   task automatic t_reset();
      expect_reg("R1", "ctrl after reset", A_CTRL, 'h0000);
      expect_reg("R1", "modulus after reset", A_MOD, 'hFFFF);
      expect_reg("R1", "count after reset", A_CNT, 'hFFFF);
      chk("R1", "irq after reset", int'(irq), 0);
   endtask

   task automatic t_reload();
      wr_reg(A_CTRL, F_OVW);
      wr_reg(A_MOD, 5);
      expect_reg("R4", "immediate load", A_CNT, 5);
      wr_reg(A_CTRL, F_EN | F_RLD | F_OVW | F_PIE);
      cyc(3);
      expect_reg("R2", "count after 3 edges at p=0", A_CNT, 2);
      cyc(3);
      expect_reg("R5", "count reloaded", A_CNT, 5);
      expect_reg("R5", "flag set on wrap", A_CTRL, 'h001F);
      chk("R11", "irq with flag and enable", int'(irq), 1);
   endtask

   task automatic t_flag_clear();
      wr_reg(A_CTRL, F_OVW);
      expect_reg("R10", "flag kept by zero write", A_CTRL, 'h0018);
      chk("R11", "irq low with enable clear", int'(irq), 0);
      wr_reg(A_CTRL, F_OVW | F_PIE);
      chk("R11", "irq high once enabled", int'(irq), 1);
      wr_reg(A_CTRL, F_OVW | F_PIF);
      expect_reg("R10", "flag cleared by one", A_CTRL, 'h0010);
      chk("R11", "irq low after clear", int'(irq), 0);
   endtask

   task automatic t_rollover();
      wr_reg(A_MOD, 2);
      wr_reg(A_CTRL, F_EN | F_OVW);
      cyc(3);
      expect_reg("R6", "rollover to all ones", A_CNT, 'hFFFF);
      expect_reg("R6", "flag after rollover", A_CTRL, 'h0019);
      chk("R11", "irq low without enable", int'(irq), 0);
      cyc(1);
      expect_reg("R6", "counting on after rollover", A_CNT, 'hFFFE);
      wr_reg(A_CTRL, F_OVW | F_PIF);
   endtask

   task automatic t_no_ovw();
      wr_reg(A_MOD, 1);
      wr_reg(A_CTRL, 0);
      wr_reg(A_MOD, 4);
      expect_reg("R4", "no load with bit 4 clear", A_CNT, 1);
      wr_reg(A_CTRL, F_EN | F_RLD);
      cyc(1);
      expect_reg("R5", "count reaches zero", A_CNT, 0);
      cyc(1);
      expect_reg("R5", "reload takes new modulus", A_CNT, 4);
      wr_reg(A_CTRL, F_OVW | F_PIF);
   endtask

   task automatic t_prescale_hold();
      wr_reg(A_MOD, 10);
      wr_reg(A_CTRL, 'h0200 | F_EN | F_OVW);
      cyc(3);
      expect_reg("R2", "no drop before 4 edges", A_CNT, 10);
      cyc(1);
      expect_reg("R2", "drop at 4 edges", A_CNT, 9);
      cyc(4);
      expect_reg("R2", "second drop 4 edges later", A_CNT, 8);
      cyc(2);
      wr_reg(A_CTRL, 'h0200 | F_OVW);
      cyc(5);
      expect_reg("R7", "count held with run clear", A_CNT, 8);
      wr_reg(A_CTRL, 'h0200 | F_EN | F_OVW);
      cyc(1);
      expect_reg("R7", "resume from held phase", A_CNT, 7);
      wr_reg(A_CTRL, 'h0200 | F_OVW);
   endtask

   task automatic t_pre_change();
      wr_reg(A_CTRL, 'h0300 | F_OVW);
      wr_reg(A_MOD, 20);
      wr_reg(A_CTRL, 'h0300 | F_EN | F_OVW);
      cyc(5);
      wr_reg(A_CTRL, 'h0200 | F_EN | F_OVW);
      cyc(3);
      expect_reg("R3", "no drop 3 edges after code change", A_CNT, 20);
      cyc(1);
      expect_reg("R3", "drop 4 edges after code change", A_CNT, 19);
      wr_reg(A_CTRL, 'h0200 | F_OVW);
   endtask

   task automatic t_load_clear();
      wr_reg(A_MOD, 30);
      wr_reg(A_CTRL, 'h0200 | F_EN | F_OVW);
      cyc(2);
      wr_reg(A_MOD, 30);
      cyc(3);
      expect_reg("R4", "load clears prescaler, no early drop", A_CNT, 30);
      cyc(1);
      expect_reg("R4", "drop 4 edges after load", A_CNT, 29);
      wr_reg(A_CTRL, F_OVW);
   endtask

   task automatic t_doze();
      wr_reg(A_MOD, 10);
      wr_reg(A_CTRL, F_DOZE | F_EN | F_OVW);
      cyc(2);
      expect_reg("R8", "running before doze", A_CNT, 8);
      doze_in = 1'b1;
      cyc(3);
      expect_reg("R8", "frozen in doze", A_CNT, 8);
      doze_in = 1'b0;
      cyc(2);
      expect_reg("R8", "resumed after doze", A_CNT, 6);
      wr_reg(A_CTRL, F_EN | F_OVW);
      doze_in = 1'b1;
      cyc(3);
      expect_reg("R8", "doze ignored with bit 6 clear", A_CNT, 2);
      doze_in = 1'b0;
      wr_reg(A_CTRL, F_OVW);
   endtask

   task automatic t_halt();
      wr_reg(A_MOD, 10);
      wr_reg(A_CTRL, F_DBG | F_EN | F_OVW);
      cyc(1);
      halt_in = 1'b1;
      cyc(4);
      expect_reg("R9", "frozen on halt", A_CNT, 9);
      halt_in = 1'b0;
      cyc(1);
      expect_reg("R9", "resumed after halt", A_CNT, 8);
      wr_reg(A_CTRL, F_OVW);
   endtask

   task automatic t_reserved();
      wr_reg(A_CTRL, 'hF0A6);
      expect_reg("R12", "reserved bits read zero", A_CTRL, 'h0026);
      wr_reg(A_CTRL, F_OVW);
   endtask

   task automatic t_user();
      int v;
      wr_reg(A_CTRL, F_EN | F_RLD | F_PIE | F_OVW, 1'b0);
      chk("R13", "error on user write", int'(last_err), 1);
      expect_reg("R13", "ctrl untouched by user write", A_CTRL, 'h0010);
      wr_reg(A_MOD, 'h1234, 1'b0);
      expect_reg("R13", "modulus untouched by user write", A_MOD, 10);
      rd_reg(A_CNT, v, 1'b0);
      chk("R13", "user read data", v, 0);
      chk("R13", "error on user read", int'(last_err), 1);
      rd_reg(A_CNT, v);
      chk("R13", "no error on privileged read", int'(last_err), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_reload();
      t_flag_clear();
      t_rollover();
      t_no_ovw();
      t_prescale_hold();
      t_pre_change();
      t_load_clear();
      t_doze();
      t_halt();
      t_reserved();
      t_user();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule